// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit sits between a shared interrupt source layer and one processor. It keeps, for its processor, a 32-bit presentation word and two further priorities. The upper 8 bits of the word hold the processor's current priority threshold. The lower 24 bits hold the number of the source now being presented. The two further priorities are the pending priority of the presented source and the requested priority of an inter-processor interrupt (IPI). Lower numbers are more favoured. The value 0xFF means nothing pending, or fully masked. Source number 0 means that no source is presented.

The source layer offers requests, each a source number with a priority. The unit either latches a request and raises its single interrupt line, or bounces the request back with a reject strobe. A more favoured request displaces the one already presented, and the displaced source is rejected explicitly so that the source layer can offer it again later.

The processor drives five commands:
- set threshold
- set IPI priority
- accept
- end-of-interrupt
- poll

From these commands the unit produces end-of-interrupt and resend strobes for the source layer. All outputs are registered and appear in the clock cycle after the operation.

Top module: `intr_presenter`

## Requirements
- R1: After reset the presentation word is 0, the pending priority and the IPI priority are 0xFF, the interrupt line is low and all strobes are low.
- R2: A request whose source number is 0, or whose priority is not strictly lower than the threshold, is bounced with a reject strobe carrying its own number, and no state changes.
- R3: A request is also bounced when a source is already presented at a pending priority equal to or lower than the request's priority.
- R4: A request that passes both tests is latched with its priority and the line is raised. If another source was presented, that displaced source number appears on the reject strobe.
- R5: Accept (cmd_op 2) returns the old word on rsp_word, lowers the line, moves the pending priority into the threshold field, clears the source field and sets the pending priority to 0xFF.
- R6: Set threshold (cmd_op 0, new value in cmd_data[7:0]) always stores the new threshold. If the new value is lower than the old one and a source is presented with a pending priority equal to or above the new value, that source is cleared and rejected, the pending priority becomes 0xFF and the line drops.
- R7: A set-threshold command with a value equal to or above the old threshold, issued while no source is presented, performs a resend. The IPI is presented first if the IPI priority is below the new threshold. The resend strobe is then pulsed.
- R8: End-of-interrupt (cmd_op 3) copies cmd_data[31:24] into the threshold and pulses the eoi strobe with cmd_data[23:0]. If no source is presented, it then performs a resend as in R7.
- R9: Set IPI priority (cmd_op 1, value in cmd_data[7:0]) stores the value. If the value is below the threshold, and no source is presented at a priority equal to or below it, the IPI is presented: any presented source is rejected, the IPI_SRC number and the IPI priority are latched, and the line is raised.
- R10: Poll (cmd_op 4) returns the word on rsp_word and the IPI priority on rsp_ipi and changes no state. Accept also returns the IPI priority on rsp_ipi.
- R11: Every strobe and response is a registered one-cycle pulse that appears in the cycle after the operation, and only for an operation that causes it.
- R12: A request that arrives in the same cycle as a command is dropped. The command is processed, and no reject is produced for the dropped request.
- R13: The interrupt line is high exactly when the source field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Presentation request strobe from the source layer |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requesting priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code: 0 threshold, 1 IPI, 2 accept, 3 EOI, 4 poll |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject strobe to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source layer |
| eoi_src | output | 24 | Source number being retired |
| resend_req | output | 1 | Request for the source layer to offer rejected sources again |
| rsp_valid | output | 1 | Response strobe for accept and poll |
| rsp_word | output | 32 | Presentation word returned |
| rsp_ipi | output | 8 | IPI priority returned |

## Verification
A wrong internal state shows up at the ports one cycle after the next operation that depends on it:
- A wrong pending priority changes which later request is rejected.
- A wrong threshold changes whether a resend or an IPI presentation happens.
- A wrong source field appears at once in the reject source or in the accept response.

Because a poll returns the word and the IPI priority without altering them, the bench can expose hidden state whenever it needs to. Accept exposes the pending priority by moving it into the threshold field.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    parameter int unsigned PRIO_W = 8;
    parameter int unsigned SRC_W  = 24;
    parameter int unsigned OP_W   = 3;
    localparam int unsigned WORD_W = PRIO_W + SRC_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam prio_t PRIO_NONE = '1;
    localparam src_t  SRC_NONE  = '0;

    typedef enum logic [OP_W-1:0] {
        OP_SET_CPPR = 3'd0,
        OP_SET_IPI  = 3'd1,
        OP_ACCEPT   = 3'd2,
        OP_EOI      = 3'd3,
        OP_POLL     = 3'd4
    } op_e;

    typedef struct packed {
        logic rej_v;
        src_t rej_src;
        logic eoi_v;
        src_t eoi_src;
        logic resend;
    } fb_t;

    typedef struct packed {
        logic  v;
        word_t word;
        prio_t ipi;
    } rsp_t;

    // a strictly more favoured than b
    function automatic logic beats(prio_t a, prio_t b);
        return a < b;
    endfunction

    function automatic word_t pack_word(prio_t thr, src_t src);
        return {thr, src};
    endfunction

    function automatic prio_t top_byte(word_t w);
        return w[WORD_W-1 -: PRIO_W];
    endfunction

endpackage

// File: rtl/ipc_req_judge.sv
module ipc_req_judge
    import ipc_pkg::*;
(
    input  src_t  req_src,
    input  prio_t req_prio,
    input  prio_t thr,
    input  src_t  cur_src,
    input  prio_t cur_pend,
    output logic  take,
    output logic  bump
);
    logic occupied;
    logic under_thr;
    logic beats_cur;

    always_comb begin
        occupied  = (cur_src != SRC_NONE);
        under_thr = beats(req_prio, thr);
        beats_cur = beats(req_prio, cur_pend);
        take      = (req_src != SRC_NONE) && under_thr && (!occupied || beats_cur);
        bump      = take && occupied;
    end
endmodule

// File: rtl/ipc_ipi_judge.sv
module ipc_ipi_judge
    import ipc_pkg::*;
(
    input  prio_t thr,
    input  prio_t ipi_prio,
    input  src_t  cur_src,
    input  prio_t cur_pend,
    output logic  show,
    output logic  bump
);
    logic occupied;
    logic held_off;

    always_comb begin
        occupied = (cur_src != SRC_NONE);
        held_off = occupied && !beats(ipi_prio, cur_pend);
        show     = beats(ipi_prio, thr) && !held_off;
        bump     = show && occupied;
    end
endmodule

// File: rtl/ipc_out_stage.sv
module ipc_out_stage
    import ipc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  fb_t  fb_d,
    input  rsp_t rsp_d,
    output fb_t  fb_q,
    output rsp_t rsp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fb_q  <= '0;
            rsp_q <= '0;
        end else begin
            fb_q  <= fb_d;
            rsp_q <= rsp_d;
        end
    end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
    import ipc_pkg::*;
#(
    parameter int unsigned IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              irq_out,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_word,
    output logic [PRIO_W-1:0] rsp_ipi
);
    localparam src_t IPI_NUM = src_t'(IPI_SRC);

    // architectural state
    prio_t cppr_q, pend_q, mfrr_q;
    src_t  xisr_q;
    logic  irq_q;

    prio_t cppr_d, pend_d, mfrr_d;
    src_t  xisr_d;
    logic  irq_d;

    fb_t  fb_d, fb_q;
    rsp_t rsp_d, rsp_q;

    op_e   op;
    prio_t arg_lo, arg_hi, new_thr, ipi_thr, ipi_val;
    logic  thr_cmd;

    logic req_take, req_bump;
    logic ipi_show, ipi_bump;

    always_comb begin
        op      = op_e'(cmd_op);
        arg_lo  = cmd_data[PRIO_W-1:0];
        arg_hi  = top_byte(cmd_data);
        new_thr = (op == OP_EOI) ? arg_hi : arg_lo;
        thr_cmd = (op == OP_SET_CPPR) || (op == OP_EOI);
        ipi_thr = thr_cmd ? new_thr : cppr_q;
        ipi_val = (op == OP_SET_IPI) ? arg_lo : mfrr_q;
    end

    ipc_req_judge u_req_judge (
        .req_src  (req_src),
        .req_prio (req_prio),
        .thr      (cppr_q),
        .cur_src  (xisr_q),
        .cur_pend (pend_q),
        .take     (req_take),
        .bump     (req_bump)
    );

    ipc_ipi_judge u_ipi_judge (
        .thr      (ipi_thr),
        .ipi_prio (ipi_val),
        .cur_src  (xisr_q),
        .cur_pend (pend_q),
        .show     (ipi_show),
        .bump     (ipi_bump)
    );

    always_comb begin
        cppr_d = cppr_q;
        pend_d = pend_q;
        mfrr_d = mfrr_q;
        xisr_d = xisr_q;
        irq_d  = irq_q;
        fb_d   = '0;
        rsp_d  = '0;

        if (cmd_valid) begin
            case (op)
                OP_SET_CPPR: begin
                    cppr_d = arg_lo;
                    if (beats(arg_lo, cppr_q)) begin
                        if ((xisr_q != SRC_NONE) && !beats(pend_q, arg_lo)) begin
                            xisr_d        = SRC_NONE;
                            pend_d        = PRIO_NONE;
                            irq_d         = 1'b0;
                            fb_d.rej_v    = 1'b1;
                            fb_d.rej_src  = xisr_q;
                        end
                    end else if (xisr_q == SRC_NONE) begin
                        if (ipi_show) begin
                            xisr_d = IPI_NUM;
                            pend_d = mfrr_q;
                            irq_d  = 1'b1;
                        end
                        fb_d.resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    mfrr_d = arg_lo;
                    if (ipi_show) begin
                        if (ipi_bump) begin
                            fb_d.rej_v   = 1'b1;
                            fb_d.rej_src = xisr_q;
                        end
                        xisr_d = IPI_NUM;
                        pend_d = arg_lo;
                        irq_d  = 1'b1;
                    end
                end
                OP_ACCEPT: begin
                    rsp_d.v    = 1'b1;
                    rsp_d.word = pack_word(cppr_q, xisr_q);
                    rsp_d.ipi  = mfrr_q;
                    cppr_d     = pend_q;
                    xisr_d     = SRC_NONE;
                    pend_d     = PRIO_NONE;
                    irq_d      = 1'b0;
                end
                OP_EOI: begin
                    cppr_d       = arg_hi;
                    fb_d.eoi_v   = 1'b1;
                    fb_d.eoi_src = cmd_data[SRC_W-1:0];
                    if (xisr_q == SRC_NONE) begin
                        if (ipi_show) begin
                            xisr_d = IPI_NUM;
                            pend_d = mfrr_q;
                            irq_d  = 1'b1;
                        end
                        fb_d.resend = 1'b1;
                    end
                end
                OP_POLL: begin
                    rsp_d.v    = 1'b1;
                    rsp_d.word = pack_word(cppr_q, xisr_q);
                    rsp_d.ipi  = mfrr_q;
                end
                default: begin
                end
            endcase
        end else if (req_valid) begin
            if (req_take) begin
                if (req_bump) begin
                    fb_d.rej_v   = 1'b1;
                    fb_d.rej_src = xisr_q;
                end
                xisr_d = req_src;
                pend_d = req_prio;
                irq_d  = 1'b1;
            end else begin
                fb_d.rej_v   = 1'b1;
                fb_d.rej_src = req_src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cppr_q <= '0;
            xisr_q <= SRC_NONE;
            pend_q <= PRIO_NONE;
            mfrr_q <= PRIO_NONE;
            irq_q  <= 1'b0;
        end else begin
            cppr_q <= cppr_d;
            xisr_q <= xisr_d;
            pend_q <= pend_d;
            mfrr_q <= mfrr_d;
            irq_q  <= irq_d;
        end
    end

    ipc_out_stage u_out_stage (
        .clk   (clk),
        .rst   (rst),
        .fb_d  (fb_d),
        .rsp_d (rsp_d),
        .fb_q  (fb_q),
        .rsp_q (rsp_q)
    );

    assign irq_out    = irq_q;
    assign rej_valid  = fb_q.rej_v;
    assign rej_src    = fb_q.rej_src;
    assign eoi_valid  = fb_q.eoi_v;
    assign eoi_src    = fb_q.eoi_src;
    assign resend_req = fb_q.resend;
    assign rsp_valid  = rsp_q.v;
    assign rsp_word   = rsp_q.word;
    assign rsp_ipi    = rsp_q.ipi;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [WORD_W-1:0] cmd_data,
    input logic              irq_out,
    input logic              rej_valid,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src,
    input logic              rsp_valid,
    input src_t              src_field,
    input prio_t             cppr_field,
    input prio_t             ipi_prio
);
    AST_IRQ_TRACKS_SRC: assert property (@(posedge clk) disable iff (rst)
        irq_out == (src_field != SRC_NONE)); // R13

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == OP_ACCEPT) |-> (!irq_out && src_field == SRC_NONE)); // R5

    AST_POLL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == OP_POLL)
        |-> ($stable(src_field) && $stable(cppr_field) && $stable(ipi_prio))); // R10

    AST_EOI_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> ($past(cmd_valid && cmd_op == OP_EOI)
                       && eoi_src == $past(cmd_data[SRC_W-1:0]))); // R8

    AST_REJ_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> $past(req_valid
                           || (cmd_valid && (cmd_op == OP_SET_CPPR || cmd_op == OP_SET_IPI)))); // R11

    AST_RSP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid && (cmd_op == OP_ACCEPT || cmd_op == OP_POLL))); // R10

    AST_CPPR_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_valid && cmd_op == OP_SET_CPPR) |-> cppr_field == $past(cmd_data[PRIO_W-1:0])); // R6
endmodule

bind intr_presenter ipc_checker u_ipc_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_data   (cmd_data),
    .irq_out    (irq_out),
    .rej_valid  (rej_valid),
    .eoi_valid  (eoi_valid),
    .eoi_src    (eoi_src),
    .rsp_valid  (rsp_valid),
    .src_field  (xisr_q),
    .cppr_field (cppr_q),
    .ipi_prio   (mfrr_q)
);

// File: tb/test_intr_presenter.sv
`timescale 1ns/1ps
module test_intr_presenter;
    import ipc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0;
    src_t        req_src = '0;
    prio_t       req_prio = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    word_t       cmd_data = '0;
    logic        irq_out, rej_valid, eoi_valid, resend_req, rsp_valid;
    src_t        rej_src, eoi_src;
    word_t       rsp_word;
    prio_t       rsp_ipi;

    intr_presenter #(.IPI_SRC(2)) i_intr_presenter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi)
    );

    localparam src_t IPI_NUM = 24'd2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    prio_t m_cppr, m_pend, m_mfrr;
    src_t  m_xisr;
    logic  m_irq;
    // expected outputs
    logic  e_rej, e_eoi, e_res, e_rsp;
    src_t  e_rsrc, e_esrc;
    word_t e_word;
    prio_t e_ipi;
    string tag;

    task automatic chk(string t, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        m_cppr = '0; m_xisr = '0; m_pend = 8'hFF; m_mfrr = 8'hFF; m_irq = 1'b0;
    endtask

    task automatic mdl_ipi(prio_t thr);
        if (m_mfrr < thr && !(m_xisr != 0 && m_pend <= m_mfrr)) begin
            if (m_xisr != 0) begin e_rej = 1'b1; e_rsrc = m_xisr; end
            m_xisr = IPI_NUM; m_pend = m_mfrr; m_irq = 1'b1;
        end
    endtask

    task automatic mdl_req(src_t s, prio_t p);
        if (s == 0 || p >= m_cppr) begin
            tag = "R2"; e_rej = 1'b1; e_rsrc = s;
        end else if (m_xisr != 0 && m_pend <= p) begin
            tag = "R3"; e_rej = 1'b1; e_rsrc = s;
        end else begin
            tag = "R4";
            if (m_xisr != 0) begin e_rej = 1'b1; e_rsrc = m_xisr; end
            m_xisr = s; m_pend = p; m_irq = 1'b1;
        end
    endtask

    task automatic mdl_cmd(logic [2:0] op, word_t d);
        prio_t old;
        case (op)
            3'd0: begin
                old = m_cppr; m_cppr = d[7:0]; tag = "R6";
                if (d[7:0] < old) begin
                    if (m_xisr != 0 && d[7:0] <= m_pend) begin
                        e_rej = 1'b1; e_rsrc = m_xisr;
                        m_xisr = '0; m_pend = 8'hFF; m_irq = 1'b0;
                    end
                end else if (m_xisr == 0) begin
                    tag = "R7"; mdl_ipi(m_cppr); e_res = 1'b1;
                end
            end
            3'd1: begin
                tag = "R9"; m_mfrr = d[7:0]; mdl_ipi(m_cppr);
            end
            3'd2: begin
                tag = "R5"; e_rsp = 1'b1; e_word = {m_cppr, m_xisr}; e_ipi = m_mfrr;
                m_cppr = m_pend; m_xisr = '0; m_pend = 8'hFF; m_irq = 1'b0;
            end
            3'd3: begin
                tag = "R8"; m_cppr = d[31:24]; e_eoi = 1'b1; e_esrc = d[23:0];
                if (m_xisr == 0) begin mdl_ipi(m_cppr); e_res = 1'b1; end
            end
            3'd4: begin
                tag = "R10"; e_rsp = 1'b1; e_word = {m_cppr, m_xisr}; e_ipi = m_mfrr;
            end
            default: tag = "R10";
        endcase
    endtask

    task automatic check_outputs(string t);
        chk(t, "irq(R13)", 64'(irq_out), 64'(m_irq));
        chk(t, "reject", {39'd0, rej_valid, rej_valid ? rej_src : 24'd0}, {39'd0, e_rej, e_rsrc});
        chk(t, "eoi", {39'd0, eoi_valid, eoi_valid ? eoi_src : 24'd0}, {39'd0, e_eoi, e_esrc});
        chk(t, "resend", 64'(resend_req), 64'(e_res));
        chk(t, "response",
            {23'd0, rsp_valid, rsp_valid ? rsp_word : 32'd0, rsp_valid ? rsp_ipi : 8'd0},
            {23'd0, e_rsp, e_word, e_ipi});
    endtask

    task automatic run_op(bit dq, src_t s, prio_t p, bit dc, logic [2:0] op, word_t d, string force_tag);
        @(negedge clk);
        req_valid = dq; req_src = s; req_prio = p;
        cmd_valid = dc; cmd_op = op; cmd_data = d;
        e_rej = 0; e_eoi = 0; e_res = 0; e_rsp = 0;
        e_rsrc = '0; e_esrc = '0; e_word = '0; e_ipi = '0; tag = "R11";
        if (dc) mdl_cmd(op, d);
        else if (dq) mdl_req(s, p);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid = 0; cmd_valid = 0;
        check_outputs(tag);
        @(negedge clk);
        // R11: pulses last one cycle
        chk("R11", "strobes idle", {60'd0, rej_valid, eoi_valid, resend_req, rsp_valid}, 64'd0);
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "irq", 64'(irq_out), 64'd0);
        chk("R1", "strobes", {60'd0, rej_valid, eoi_valid, resend_req, rsp_valid}, 64'd0);
        run_op(0, 0, 0, 1, 3'd4, 0, "R1");                    // poll: word 0, ipi FF
        run_op(0, 0, 0, 1, 3'd0, 32'h10, "R7");               // raise threshold, resend
        run_op(1, 24'd5, 8'h10, 0, 0, 0, "R2");               // equal to threshold
        run_op(1, 24'd0, 8'h01, 0, 0, 0, "R2");               // source 0
        run_op(1, 24'd5, 8'h08, 0, 0, 0, "R4");
        run_op(1, 24'd6, 8'h08, 0, 0, 0, "R3");
        run_op(1, 24'd7, 8'h03, 0, 0, 0, "R4");               // displaces 5
        run_op(0, 0, 0, 1, 3'd1, 32'h03, "R9");               // held off by equal pending
        run_op(0, 0, 0, 1, 3'd1, 32'h01, "R9");               // displaces 7
        run_op(0, 0, 0, 1, 3'd2, 0, "R5");
        run_op(0, 0, 0, 1, 3'd3, 32'h1000_0002, "R8");        // resend re-presents IPI
        run_op(0, 0, 0, 1, 3'd1, 32'hFF, "R9");
        run_op(0, 0, 0, 1, 3'd0, 32'h00, "R6");               // more favoured, clears IPI
        run_op(0, 0, 0, 1, 3'd4, 0, "R10");
        run_op(0, 0, 0, 1, 3'd0, 32'h20, "R7");
        run_op(1, 24'd9, 8'h04, 1, 3'd4, 0, "R12");           // request dropped
        run_op(0, 0, 0, 1, 3'd4, 0, "R12");

        for (int i = 0; i < 700; i++) begin
            int k = $urandom_range(0, 9);
            prio_t p = ($urandom_range(0, 7) == 0) ? 8'hFF : prio_t'($urandom_range(0, 15));
            src_t  s = src_t'($urandom_range(0, 20));
            word_t d = {p, src_t'($urandom_range(1, 20))};
            if (k < 4)       run_op(1, s, p, 0, 0, 0, "");
            else if (k == 4) run_op(0, 0, 0, 1, 3'd0, {24'd0, p}, "");
            else if (k == 5) run_op(0, 0, 0, 1, 3'd1, {24'd0, p}, "");
            else if (k == 6) run_op(0, 0, 0, 1, 3'd2, 0, "");
            else if (k == 7) run_op(0, 0, 0, 1, 3'd3, d, "");
            else if (k == 8) run_op(0, 0, 0, 1, 3'd4, 0, "");
            else             run_op(1, s, p, 1, 3'd4, 0, "R12");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule